// File: doc/BRIEF.md
# Learning Bridge Forwarding Table

This block makes the forwarding decision for each frame in a small multi-port Ethernet bridge. A frame is presented for one cycle with its destination address, its source address and the port it arrived on. Every table entry compares its stored address with the destination at the same time. One cycle later the block returns an output port mask, a hit flag, the index of the matching entry and the port stored in that entry.

In the same cycle the source address is learned against the ingress port. A known address is refreshed. An unknown address takes the lowest free entry, or the oldest entry when no entry is free. A shared aging tick advances a per-entry age. An entry is dropped when its age reaches a programmable limit.

A known unicast destination goes to its single stored port. Group and unknown traffic is flooded. Ports that spanning tree has blocked are removed from the mask, and so is the ingress port.

Top module: `bridge_fwd_table`

## Requirements
- R1: During and right after reset, `resp_valid` is 0 and the table holds no entries, so the first lookup reports `hit` = 0.
- R2: A request with `req_valid` = 1 yields `resp_valid` = 1 on the next cycle. When the unicast destination is in the table, the response has `hit` = 1, the entry index and the stored port, and `out_mask` has only the stored port's bit set (bit n stands for port n).
- R3: A destination whose first octet has its least significant bit set is a group address; with bits 47:40 holding the first octet, that bit is `dst_mac[40]`. The all-ones address is broadcast. Both kinds are flooded: `out_mask` starts from all ports.
- R4: A unicast destination that is not in the table is flooded and reports `hit` = 0, `hit_index` = 0 and `hit_port` = 0.
- R5: The ingress port's bit is always 0 in `out_mask`. A known unicast destination stored on the ingress port gives `out_mask` = 0.
- R6: A port whose `port_blocked` bit is 1 in the request cycle has a 0 in that response's `out_mask`.
- R7: Each request learns its source address against `in_port`. If the address is already in the table, its port is overwritten and its age goes back to 0. Lookups see the change from the next request on.
- R8: A new source address is written into the lowest-numbered free entry.
- R9: When no entry is free, a new source address replaces the entry with the largest age, choosing the lowest index among equal ages.
- R10: On each cycle with `age_tick` = 1, every valid entry that is not being written gains 1 in age. An entry whose new age would reach `age_limit` is removed instead.
- R11: No address is ever held in two valid entries at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A frame is presented this cycle |
| dst_mac | input | 48 | Destination address, first octet in bits 47:40 |
| src_mac | input | 48 | Source address, learned against the ingress port |
| in_port | input | 2 | Ingress port number |
| port_blocked | input | 4 | Per-port blocked state from spanning tree |
| age_tick | input | 1 | Aging step for all valid entries |
| age_limit | input | 4 | Age at which an entry is removed |
| resp_valid | output | 1 | Decision for the previous cycle's frame |
| out_mask | output | 4 | Ports the frame is sent to |
| hit | output | 1 | Destination was found in the table |
| hit_index | output | 3 | Index of the matching entry |
| hit_port | output | 2 | Port stored in the matching entry |

## Verification
The assertions on ingress exclusion and blocked ports assume that `in_port` and `port_blocked` hold stable meaning for the one cycle between a request and its response. They do not assume any relationship between the source and destination addresses. The age bound is claimed only while `age_limit` is nonzero and unchanged across a tick. For that reason the stimulus keeps the limit fixed during each phase and changes it only while no ticks occur. Random frames use a small pool of addresses so that refreshes, evictions and expiries happen often, and `in_port` always names an existing port.

// File: rtl/bft_pkg.sv
package bft_pkg;

  // Group (multicast or broadcast) address: least significant bit of first octet.
  function automatic logic mac_is_group(input logic [47:0] mac);
    return mac[40];
  endfunction

  function automatic logic mac_is_bcast(input logic [47:0] mac);
    return &mac;
  endfunction

  // Aged value would reach the limit: entry must be dropped on this tick.
  function automatic logic age_reaches(input logic [7:0] age, input logic [7:0] limit);
    return ({1'b0, age} + 9'd1) >= {1'b0, limit};
  endfunction

endpackage

// File: rtl/bft_entry.sv
module bft_entry #(
  parameter int PW    = 2,
  parameter int AGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [47:0]       dst_mac,
  input  logic [47:0]       src_mac,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_port,
  input  logic              age_tick,
  input  logic [AGE_W-1:0]  age_limit,
  output logic              valid,
  output logic [PW-1:0]     port,
  output logic [AGE_W-1:0]  age,
  output logic              dst_match,
  output logic              src_match
);
  import bft_pkg::*;

  logic [47:0] mac_q;
  logic        expire;

  assign expire    = age_reaches(8'(age), 8'(age_limit));
  assign dst_match = valid && (mac_q == dst_mac);
  assign src_match = valid && (mac_q == src_mac);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      mac_q <= '0;
      port  <= '0;
      age   <= '0;
    end else if (wr_en) begin
      valid <= 1'b1;
      mac_q <= src_mac;
      port  <= wr_port;
      age   <= '0;
    end else if (age_tick && valid) begin
      if (expire) begin
        valid <= 1'b0;
        age   <= '0;
      end else begin
        age <= age + 1'b1;
      end
    end
  end

  assert_age_below_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(age_tick) && $stable(age_limit) && (age_limit != '0) |-> age < age_limit);

endmodule

// File: rtl/bft_select.sv
module bft_select #(
  parameter int DEPTH = 8,
  parameter int AGE_W = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]       dst_match,
  input  logic [DEPTH-1:0]       src_match,
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH*AGE_W-1:0] ages,
  output logic                   dst_hit,
  output logic [IW-1:0]          dst_idx,
  output logic [IW-1:0]          wr_idx
);

  logic          src_hit, any_free;
  logic [IW-1:0] src_idx, free_idx, old_idx;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    dst_hit  = 1'b0; dst_idx  = '0;
    src_hit  = 1'b0; src_idx  = '0;
    any_free = 1'b0; free_idx = '0;
    old_idx  = '0;   old_age  = ages[AGE_W-1:0];
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (dst_match[i]) begin dst_hit = 1'b1; dst_idx = IW'(i); end
      if (src_match[i]) begin src_hit = 1'b1; src_idx = IW'(i); end
      if (!valid[i])    begin any_free = 1'b1; free_idx = IW'(i); end
    end
    for (int i = 1; i < DEPTH; i++) begin
      if (ages[i*AGE_W +: AGE_W] > old_age) begin
        old_age = ages[i*AGE_W +: AGE_W];
        old_idx = IW'(i);
      end
    end
    if (src_hit)       wr_idx = src_idx;
    else if (any_free) wr_idx = free_idx;
    else               wr_idx = old_idx;
  end

endmodule

// File: rtl/bridge_fwd_table.sv
module bridge_fwd_table #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 4,
  localparam int PW    = $clog2(NPORTS),
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [47:0]       dst_mac,
  input  logic [47:0]       src_mac,
  input  logic [PW-1:0]     in_port,
  input  logic [NPORTS-1:0] port_blocked,
  input  logic              age_tick,
  input  logic [AGE_W-1:0]  age_limit,
  output logic              resp_valid,
  output logic [NPORTS-1:0] out_mask,
  output logic              hit,
  output logic [IW-1:0]     hit_index,
  output logic [PW-1:0]     hit_port
);
  import bft_pkg::*;

  function automatic logic [NPORTS-1:0] port_bit(input logic [PW-1:0] p);
    return NPORTS'(1) << p;
  endfunction

  logic [DEPTH-1:0]       dst_match, src_match, valid, wr_en;
  logic [DEPTH*AGE_W-1:0] ages;
  logic [PW-1:0]          ports [DEPTH];
  logic                   dst_hit;
  logic [IW-1:0]          dst_idx, wr_idx;
  logic                   flood;
  logic [NPORTS-1:0]      base_mask, next_mask;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign wr_en[g] = req_valid && (wr_idx == IW'(g));
    bft_entry #(.PW(PW), .AGE_W(AGE_W)) u_entry (
      .clk(clk), .rst_n(rst_n), .dst_mac(dst_mac), .src_mac(src_mac),
      .wr_en(wr_en[g]), .wr_port(in_port), .age_tick(age_tick),
      .age_limit(age_limit), .valid(valid[g]), .port(ports[g]),
      .age(ages[g*AGE_W +: AGE_W]), .dst_match(dst_match[g]),
      .src_match(src_match[g])
    );
  end

  bft_select #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_select (
    .dst_match(dst_match), .src_match(src_match), .valid(valid), .ages(ages),
    .dst_hit(dst_hit), .dst_idx(dst_idx), .wr_idx(wr_idx)
  );

  assign flood     = mac_is_group(dst_mac) || mac_is_bcast(dst_mac) || !dst_hit;
  assign base_mask = flood ? {NPORTS{1'b1}} : port_bit(ports[dst_idx]);
  assign next_mask = base_mask & ~port_blocked & ~port_bit(in_port);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      out_mask   <= '0;
      hit        <= 1'b0;
      hit_index  <= '0;
      hit_port   <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        out_mask  <= next_mask;
        hit       <= dst_hit;
        hit_index <= dst_hit ? dst_idx : '0;
        hit_port  <= dst_hit ? ports[dst_idx] : '0;
      end
    end
  end

  assert_unique_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_match) && $onehot0(dst_match));

  assert_ingress_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !out_mask[$past(in_port)]);

  assert_blocked_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_mask & $past(port_blocked)) == '0);

  assert_unicast_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && dst_hit && !mac_is_group(dst_mac) |=> $countones(out_mask) <= 1);

  assert_learned_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> valid[$past(wr_idx)]);

endmodule

// File: tb/bridge_fwd_table_test.sv
module bridge_fwd_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4, DEP = 8;

  logic        clk = 0, rst_n = 0, req_valid = 0, age_tick = 0;
  logic [47:0] dst_mac = '0, src_mac = '0;
  logic [1:0]  in_port = '0;
  logic [3:0]  port_blocked = '0, age_limit = 4'd3;
  logic        resp_valid, hit;
  logic [3:0]  out_mask;
  logic [2:0]  hit_index;
  logic [1:0]  hit_port;

  int n_checks = 0, n_fail = 0;

  // bench model of the table
  logic [47:0] m_mac [DEP];
  int          m_port[DEP], m_age[DEP];
  bit          m_val [DEP];
  // expected response
  bit   e_hit; int e_idx, e_port; logic [3:0] e_mask;

  bridge_fwd_table uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report_end();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    report_end();
  end

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [47:0] d, logic [3:0] blk);
    if (d[40]) return "R3";
    if (!e_hit) return "R4";
    if (e_port == int'(in_port)) return "R5";
    if (blk != 0) return "R6";
    return "R2";
  endfunction

  function automatic void model_step(bit req, logic [47:0] s, logic [47:0] d,
                                     int ip, logic [3:0] blk, bit tick, int lim);
    int w, best;
    bit found;
    logic [3:0] m;
    e_hit = 0; e_idx = 0; e_port = 0;
    for (int i = 0; i < DEP; i++)
      if (m_val[i] && m_mac[i] == d) begin e_hit = 1; e_idx = i; e_port = m_port[i]; end
    m = (d[40] || !e_hit) ? 4'hF : 4'(1 << e_port);
    e_mask = m & ~blk & ~4'(1 << ip);
    w = -1;
    for (int i = 0; i < DEP; i++) if (w < 0 && m_val[i] && m_mac[i] == s) w = i;
    for (int i = 0; i < DEP; i++) if (w < 0 && !m_val[i]) w = i;
    if (w < 0) begin
      best = 0;
      for (int i = 1; i < DEP; i++) if (m_age[i] > m_age[best]) best = i;
      w = best;
    end
    for (int i = 0; i < DEP; i++) begin
      if (req && i == w) begin
        m_val[i] = 1; m_mac[i] = s; m_port[i] = ip; m_age[i] = 0;
      end else if (tick && m_val[i]) begin
        if (m_age[i] + 1 >= lim) begin m_val[i] = 0; m_age[i] = 0; end
        else m_age[i]++;
      end
    end
  endfunction

  task automatic send(logic [47:0] s, logic [47:0] d, int ip, logic [3:0] blk, bit tick);
    string t;
    req_valid = 1; src_mac = s; dst_mac = d; in_port = 2'(ip);
    port_blocked = blk; age_tick = tick;
    model_step(1, s, d, ip, blk, tick, int'(age_limit));
    t = tag_of(d, blk);
    @(negedge clk);
    req_valid = 0; age_tick = 0;
    check(t, "resp_valid", int'(resp_valid), 1);
    check(t, "out_mask", int'(out_mask), int'(e_mask));
    check(t, "hit", int'(hit), int'(e_hit));
    check(t, "hit_index", int'(hit_index), e_idx);
    check(t, "hit_port", int'(hit_port), e_port);
  endtask

  task automatic tick_only();
    age_tick = 1;
    model_step(0, '0, '0, 0, '0, 1, int'(age_limit));
    @(negedge clk);
    age_tick = 0;
    check("R10", "resp_valid idle", int'(resp_valid), 0);
  endtask

  function automatic logic [47:0] umac(int k);
    return 48'h0200_0000_0000 | 48'(k);
  endfunction

  localparam logic [47:0] BCAST = '1;
  localparam logic [47:0] MCAST = 48'h0100_5E00_0001;

  initial begin
    for (int i = 0; i < DEP; i++) begin m_val[i] = 0; m_mac[i] = '0; m_port[i] = 0; m_age[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "resp_valid in reset", int'(resp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "resp_valid after reset", int'(resp_valid), 0);

    // R1/R4: empty table, unknown destination floods minus ingress
    send(umac(1), umac(9), 1, 4'h0, 0);
    check("R1", "first lookup mask", int'(out_mask), 4'hD);
    // R2/R8: A learned at entry 0 on port 1
    send(umac(2), umac(1), 2, 4'h0, 0);
    check("R8", "index of first entry", int'(hit_index), 0);
    check("R2", "unicast mask", int'(out_mask), 4'h2);
    send(umac(3), umac(2), 0, 4'h0, 0);
    check("R8", "index of second entry", int'(hit_index), 1);
    // R3: broadcast, and R7 move A to port 3
    send(umac(1), BCAST, 3, 4'h0, 0);
    check("R3", "broadcast mask", int'(out_mask), 4'h7);
    send(umac(4), umac(1), 1, 4'h0, 0);
    check("R7", "moved port", int'(hit_port), 3);
    // R5: destination on ingress port
    send(umac(4), umac(1), 3, 4'h0, 0);
    check("R5", "hairpin mask", int'(out_mask), 0);
    // R3/R6: multicast with a blocked port
    send(umac(5), MCAST, 0, 4'h4, 0);
    check("R6", "multicast blocked mask", int'(out_mask), 4'hA);
    // R10: limit 2, two ticks clear everything
    age_limit = 4'd2;
    tick_only(); tick_only();
    send(umac(6), umac(1), 0, 4'h0, 0);
    check("R10", "aged entry gone", int'(hit), 0);
    // R9: fill with ascending age then evict oldest
    age_limit = 4'd15;
    tick_only(); tick_only();
    for (int k = 0; k < DEP; k++) send(umac(16 + k), BCAST, k % NP, 4'h0, 1);
    send(umac(40), umac(16), 0, 4'h0, 0);
    check("R9", "oldest still present before eviction", int'(hit), 1);
    send(umac(41), umac(40), 1, 4'h0, 0);
    check("R9", "evictor hit", int'(hit), 1);
    send(umac(41), umac(16), 1, 4'h0, 0);
    check("R9", "evicted entry gone", int'(hit), 0);

    // random phase
    age_limit = 4'd6;
    void'($urandom(32'h5EED));
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 16;
      logic [47:0] d = (r == 0) ? BCAST : (r == 1) ? MCAST : umac($urandom % 12);
      logic [3:0] blk = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      send(umac($urandom % 12), d, $urandom % NP, blk, ($urandom % 5) == 0);
      if ($urandom % 8 == 0) tick_only();
    end
    report_end();
  end
endmodule